// File: doc/BRIEF.md
# Temperature-Aware Refresh Interval Scheduler

This block paces auto-refresh for an SDRAM controller. It counts clock cycles against a refresh interval derived from the configured clock period. Each time an interval expires it adds one refresh to a pending count and raises a request. The controller drains the count with single-cycle acknowledges. Issuing the refresh command on the DRAM bus, and measuring the temperature, are left to other blocks.

The interval depends on a reported case-temperature band. The normal band (up to 85 °C) uses the long interval, nominally 7.8 µs. Every hotter band uses half of that, nominally 3.9 µs, which doubles the refresh rate. The hotter bands also drive a flag that the controller copies into the high-temperature self-refresh enable bit of its extended mode register. The band above 95 °C is legal only on the extended-temperature grade, which is chosen by a parameter. Otherwise that band is flagged as an error, and it is still refreshed at the fast rate.

Top module: `refresh_sched`

## Requirements
- R1: While reset is asserted and right after it, `ref_req`, `ref_pending`, `hot_sr_en` and `band_err` are all 0.
- R2: With `temp_band` = 0 (at or below 85 °C), expiries are spaced floor(T_NORM_PS / `tck_ps`) clock cycles apart.
- R3: With `temp_band` = 1 (85–95 °C), 2 (95–105 °C) or 3 (reserved), expiries are spaced floor(T_HOT_PS / `tck_ps`) cycles apart.
- R4: If that quotient is 0 (a period longer than the interval), an interval of 1 cycle is used, so refresh is never late.
- R5: Reset is released through a two-stage synchronizer. The first expiry therefore lands N+3 cycles after `rst_n` rises, where N is the interval.
- R6: A change of `temp_band` or `tck_ps` does not shorten or stretch the interval already running. It takes effect when the next interval is loaded.
- R7: Each expiry raises `ref_pending` by one. The count saturates at PEND_MAX (8).
- R8: `ref_req` is 1 exactly when `ref_pending` is non-zero.
- R9: An acknowledge while `ref_pending` > 0 lowers the count by one. An acknowledge while the count is 0 is ignored. An acknowledge in the same cycle as an expiry leaves the count unchanged, including at saturation.
- R10: `hot_sr_en` is 1 one cycle after `temp_band` is 1, 2 or 3, and 0 one cycle after it is 0.
- R11: `band_err` is 1 one cycle after `temp_band` is 3. It is also 1 one cycle after `temp_band` is 2 when EXT_GRADE = 0. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| temp_band | input | 2 | Case-temperature band code: 0 = ≤85 °C, 1 = 85–95 °C, 2 = 95–105 °C, 3 = reserved |
| tck_ps | input | PER_W | Clock period in picoseconds |
| ref_ack | input | 1 | Controller has issued one refresh |
| ref_req | output | 1 | At least one refresh is pending |
| ref_pending | output | PEND_W | Number of refreshes owed |
| hot_sr_en | output | 1 | High-temperature self-refresh enable for the mode register |
| band_err | output | 1 | The reported band is not supported by this grade |

## Verification
The bench keeps the real 7.8 µs and 3.9 µs intervals and supplies clock periods of 100 ns to 9 µs. This keeps every interval between 1 and 78 cycles. A 9 µs period makes the quotient zero, so expiries come every cycle. That reaches saturation of the pending count, and an acknowledge landing on an expiry, within a few cycles. Two instances are built, one with EXT_GRADE = 0 and one with EXT_GRADE = 1. This lets the 95–105 °C band be seen both as an error and as legal.

// File: rtl/refsch_pkg.sv
package refsch_pkg;
  typedef enum logic [1:0] {
    BAND_NORMAL = 2'd0,
    BAND_HOT    = 2'd1,
    BAND_XHOT   = 2'd2,
    BAND_RSVD   = 2'd3
  } temp_band_e;

  function automatic logic band_is_hot(input logic [1:0] b);
    return b != BAND_NORMAL;
  endfunction

  function automatic logic band_is_bad(input logic [1:0] b, input bit ext_ok);
    return (b == BAND_RSVD) || ((b == BAND_XHOT) && !ext_ok);
  endfunction
endpackage

// File: rtl/refsch_interval.sv
module refsch_interval #(
  parameter int unsigned T_NORM_PS = 7_800_000,
  parameter int unsigned T_HOT_PS  = 3_900_000,
  parameter int unsigned PER_W     = 24,
  parameter int unsigned CNT_W     = 23
) (
  input  logic [1:0]       band,
  input  logic [PER_W-1:0] period_ps,
  output logic [CNT_W-1:0] interval
);
  import refsch_pkg::*;

  logic [31:0] span_ps;
  logic [31:0] per_safe;
  logic [31:0] quot;

  always_comb begin
    span_ps  = band_is_hot(band) ? 32'(T_HOT_PS) : 32'(T_NORM_PS);
    per_safe = (period_ps == '0) ? 32'd1 : 32'(period_ps);
    quot     = span_ps / per_safe;
    if (quot == 32'd0) interval = CNT_W'(1);
    else               interval = quot[CNT_W-1:0];
  end
endmodule

// File: rtl/refsch_timer.sv
module refsch_timer #(
  parameter int unsigned CNT_W = 23
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] interval,
  output logic             expire
);
  logic             armed_q, armed_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    armed_d = armed_q;
    cnt_d   = cnt_q;
    expire  = 1'b0;
    cnt_en  = 1'b1;
    if (!armed_q) begin
      armed_d = 1'b1;
      cnt_d   = interval - CNT_W'(1);
    end else if (cnt_q == '0) begin
      expire = 1'b1;
      cnt_d  = interval - CNT_W'(1);
    end else begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (cnt_en) begin
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
    end
  end
endmodule

// File: rtl/refsch_pending.sv
module refsch_pending #(
  parameter int unsigned PEND_MAX = 8,
  parameter int unsigned PEND_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc,
  input  logic              ack,
  output logic [PEND_W-1:0] count
);
  localparam logic [PEND_W-1:0] CAP = PEND_W'(PEND_MAX);

  logic [PEND_W-1:0] cnt_q, cnt_d;
  logic              dec, upd;

  always_comb begin
    dec   = ack && (cnt_q != '0);
    upd   = inc || dec;
    cnt_d = cnt_q;
    if (inc && !dec) begin
      if (cnt_q != CAP) cnt_d = cnt_q + PEND_W'(1);
    end else if (dec && !inc) begin
      cnt_d = cnt_q - PEND_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (upd) cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched #(
  parameter int unsigned T_NORM_PS = 7_800_000,
  parameter int unsigned T_HOT_PS  = 3_900_000,
  parameter int unsigned PER_W     = 24,
  parameter int unsigned PEND_MAX  = 8,
  parameter bit          EXT_GRADE = 1'b0,
  localparam int unsigned CNT_W    = $clog2(T_NORM_PS + 1),
  localparam int unsigned PEND_W   = $clog2(PEND_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        temp_band,
  input  logic [PER_W-1:0]  tck_ps,
  input  logic              ref_ack,
  output logic              ref_req,
  output logic [PEND_W-1:0] ref_pending,
  output logic              hot_sr_en,
  output logic              band_err
);
  import refsch_pkg::*;

  logic             rst_s1, rst_q;
  logic [CNT_W-1:0] interval;
  logic             expire;
  logic             hot_d, err_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_q  <= rst_s1;
    end
  end

  refsch_interval #(
    .T_NORM_PS(T_NORM_PS), .T_HOT_PS(T_HOT_PS), .PER_W(PER_W), .CNT_W(CNT_W)
  ) u_ival (
    .band(temp_band), .period_ps(tck_ps), .interval(interval)
  );

  refsch_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_q), .interval(interval), .expire(expire)
  );

  refsch_pending #(.PEND_MAX(PEND_MAX), .PEND_W(PEND_W)) u_pend (
    .clk(clk), .rst_n(rst_q), .inc(expire), .ack(ref_ack), .count(ref_pending)
  );

  always_comb begin
    hot_d = band_is_hot(temp_band);
    err_d = band_is_bad(temp_band, EXT_GRADE);
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      hot_sr_en <= 1'b0;
      band_err  <= 1'b0;
    end else begin
      hot_sr_en <= hot_d;
      band_err  <= err_d;
    end
  end

  assign ref_req = ref_pending != '0;
endmodule

// File: rtl/refsch_chk.sv
module refsch_chk #(
  parameter int unsigned PEND_MAX = 8,
  parameter int unsigned PEND_W   = 4
) (
  input logic              clk,
  input logic              rst_q,
  input logic              ref_ack,
  input logic              expire,
  input logic              ref_req,
  input logic [PEND_W-1:0] ref_pending,
  input logic              hot_sr_en,
  input logic              band_err
);
  p_req_tracks_pending_r8: assert property (@(posedge clk) disable iff (!rst_q)
    ref_req == (ref_pending != '0));

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_q)
    ref_pending <= PEND_W'(PEND_MAX));

  p_expire_counts_r7: assert property (@(posedge clk) disable iff (!rst_q)
    (expire && !ref_ack && ref_pending != PEND_W'(PEND_MAX)) |=> ref_pending == $past(ref_pending) + PEND_W'(1));

  p_ack_decrements_r9: assert property (@(posedge clk) disable iff (!rst_q)
    (ref_ack && !expire && ref_pending != '0) |=> ref_pending == $past(ref_pending) - PEND_W'(1));

  p_ack_meets_expire_r9: assert property (@(posedge clk) disable iff (!rst_q)
    (ref_ack && expire && ref_pending != '0) |=> $stable(ref_pending));

  p_idle_holds_r9: assert property (@(posedge clk) disable iff (!rst_q)
    (!ref_ack && !expire) |=> $stable(ref_pending));

  p_err_implies_hot_r11: assert property (@(posedge clk) disable iff (!rst_q)
    band_err |-> hot_sr_en);
endmodule

bind refresh_sched refsch_chk #(.PEND_MAX(PEND_MAX), .PEND_W(PEND_W)) u_chk (
  .clk(clk), .rst_q(rst_q), .ref_ack(ref_ack), .expire(expire),
  .ref_req(ref_req), .ref_pending(ref_pending),
  .hot_sr_en(hot_sr_en), .band_err(band_err)
);

// File: tb/sim_refresh_sched.sv
`timescale 1ns/1ps
module sim_refresh_sched;
  logic        clk;
  logic        rst_n;
  logic [1:0]  temp_band;
  logic [23:0] tck_ps;
  logic        ref_ack;
  logic        req0, req1, hot0, hot1, err0, err1;
  logic [3:0]  pend0, pend1;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  refresh_sched #(.EXT_GRADE(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .temp_band(temp_band), .tck_ps(tck_ps), .ref_ack(ref_ack),
    .ref_req(req0), .ref_pending(pend0), .hot_sr_en(hot0), .band_err(err0));

  refresh_sched #(.EXT_GRADE(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .temp_band(temp_band), .tck_ps(tck_ps), .ref_ack(ref_ack),
    .ref_req(req1), .ref_pending(pend1), .hot_sr_en(hot1), .band_err(err1));

  // {period_ps[24], band[2], interval[23], hot, err(EXT_GRADE=0)}
  localparam int NV = 8;
  localparam logic [50:0] VEC [NV] = '{
    {24'd100000,  2'd0, 23'd78, 1'b0, 1'b0},  // R2
    {24'd100000,  2'd1, 23'd39, 1'b1, 1'b0},  // R3
    {24'd130000,  2'd0, 23'd60, 1'b0, 1'b0},  // R2
    {24'd130000,  2'd1, 23'd30, 1'b1, 1'b0},  // R3
    {24'd333000,  2'd0, 23'd23, 1'b0, 1'b0},  // R2 floor
    {24'd333000,  2'd1, 23'd11, 1'b1, 1'b0},  // R3 floor
    {24'd100000,  2'd2, 23'd39, 1'b1, 1'b1},  // R3 R11
    {24'd9000000, 2'd3, 23'd1,  1'b1, 1'b1}   // R4 R11
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    ref_ack = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
  endtask

  // counts negedges until pend0 reaches target
  task automatic wait_pend(input int target, output int n);
    n = 0;
    while (int'(pend0) != target && n < 2000) begin
      tick();
      n++;
    end
  endtask

  task automatic pulse_ack;
    ref_ack = 1'b1;
    tick();
    ref_ack = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    temp_band = 2'd0;
    tck_ps    = 24'd100000;
    ref_ack   = 1'b0;
    rst_n     = 1'b0;
    repeat (2) tick();
    // R1 reset state
    check("R1 req", req0, 0);
    check("R1 pend", pend0, 0);
    check("R1 hot", hot0, 0);
    check("R1 err", err0, 0);
    rst_n = 1'b1;
    tick();
    check("R1 pend after release", pend0, 0);

    // R5 first expiry latency: 78 + 3
    do_reset();
    wait_pend(1, n);
    check("R5 first expiry", n, 81);

    foreach (VEC[i]) begin
      tck_ps    = VEC[i][50:27];
      temp_band = VEC[i][26:25];
      do_reset();
      wait_pend(1, n);
      wait_pend(2, n);
      check($sformatf("R2/R3/R4 interval vec%0d", i), n, int'(VEC[i][24:2]));
      check($sformatf("R10 hot vec%0d", i), hot0, int'(VEC[i][1]));
      check($sformatf("R11 err vec%0d", i), err0, int'(VEC[i][0]));
    end
    // R11 extended grade accepts band 2
    temp_band = 2'd2;
    tick();
    check("R11 ext grade band2", err1, 0);
    check("R10 ext grade hot", hot1, 1);

    // R6 band change mid-interval
    tck_ps = 24'd100000; temp_band = 2'd0;
    do_reset();
    wait_pend(1, n);
    repeat (10) tick();
    temp_band = 2'd1;
    tick();
    check("R10 hot follows band", hot0, 1);
    wait_pend(2, n);
    check("R6 running interval kept", n + 11, 78);
    wait_pend(3, n);
    check("R6 new interval at reload", n, 39);

    // R9 ack decrement, R8 req
    pulse_ack();
    check("R9 ack decrements", pend0, 2);
    pulse_ack();
    pulse_ack();
    check("R9 drained", pend0, 0);
    check("R8 req low at zero", req0, 0);
    pulse_ack();
    check("R9 ack at zero ignored", pend0, 0);
    wait_pend(1, n);
    check("R9 no wrap after idle ack", pend0, 1);
    check("R8 req high", req0, 1);

    // R7 saturation with 1-cycle interval
    tck_ps = 24'd9000000; temp_band = 2'd0;
    do_reset();
    repeat (20) tick();
    check("R7 saturates", pend0, 8);
    check("R8 req at cap", req0, 1);
    // R9 ack meeting expiry at cap
    ref_ack = 1'b1;
    repeat (3) tick();
    check("R9 ack with expiry at cap", pend0, 8);
    // R6 longer period applied at next reload, then drain
    tck_ps = 24'd100000;
    tick();
    ref_ack = 1'b0;
    check("R9 ack with expiry holds", pend0, 8);
    repeat (8) pulse_ack();
    check("R9 drain to zero", pend0, 0);
    check("R8 req low", req0, 0);
    repeat (5) tick();
    check("R6 slow interval now running", pend0, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule